// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Mode Controller

This block is the control register set of a CAN receive acceptance filter. It has an APB slave port. Behind that port sit one mode register and five section boundary registers. The boundary registers give the limits of the identifier lookup table to the search engine that sits next to this block. The controller turns the three mode bits into one operating mode with a fixed priority. The four modes are: drop every frame, pass every frame, screen frames through the lookup, and screen with hardware frame storage. It also raises a halt line that holds the lookup search state machine in reset while filtering is not active.

For each CAN bus, a frame-received strobe produces a registered accept or reject decision one clock later. In pass-all mode the frame is accepted. In drop-all mode it is rejected. In the two screening modes the decision follows the lookup engine's hit input. A bus whose enable input is low always gets a reject. The boundary registers are write-protected: a write takes effect only while the filter is halted. A write at any other time is dropped silently and the bus transfer still completes normally. A hardware request line can force the filter into the drop-all mode at any time.

Top module: `acf_ctl`

## Requirements
- R1: After reset, the mode register reads 0x1 at byte offset 0x00 and every boundary register reads 0. The mode output is drop-all (code 0) and the halt output is 1.
- R2: Mode register bits are: bit 0 = off, bit 1 = bypass, bit 2 = hardware storage. A write stores bits 2:0 only. Bits 31:3 always read 0.
- R3: Mode decode, by priority. Bypass = 1 gives pass-all (code 1), whatever the off bit holds. Otherwise off = 1 gives drop-all (code 0). Otherwise storage = 0 gives screen (code 2) and storage = 1 gives screen with storage (code 3).
- R4: The halt output is 1 exactly while the mode is drop-all or pass-all.
- R5: Boundary register k (k = 0..4) sits at byte offset 4*(k+1). It stores write-data bits 9:0 while halt is 1. Reads return the stored value zero-extended.
- R6: A boundary register write while halt is 0 leaves the register unchanged, and pslverr stays 0 during that transfer.
- R7: A one-cycle pulse on hw_off_req sets the off bit at the next clock edge. This leaves the filter in drop-all unless bypass is set.
- R8: dec_valid[b] is 1 in the cycle after rx_strobe[b] was 1. dec_accept[b] gives the decision for that frame: 1 in pass-all, 0 in drop-all, and screen_hit[b] in the two screening modes. These are all taken in the strobe cycle.
- R9: When bus_en[b] was 0 in the strobe cycle, dec_accept[b] is 0 whatever the mode.
- R10: pready is always 1 and pslverr is always 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| hw_off_req | input | 1 | Hardware request to set the off bit |
| rx_strobe | input | NUM_BUS | One-cycle frame-received strobe per bus |
| bus_en | input | NUM_BUS | Per-bus controller enable |
| screen_hit | input | NUM_BUS | Lookup engine match result per bus |
| filt_mode | output | 2 | Decoded mode (0 drop, 1 pass, 2 screen, 3 screen+store) |
| filt_halt | output | 1 | Reset/halt for the lookup search machine |
| sect_bound | output | NUM_SECT*SECT_W | Boundary registers, section 0 in the low bits |
| dec_valid | output | NUM_BUS | Decision valid per bus |
| dec_accept | output | NUM_BUS | Accept (1) or reject (0) per bus |

## Verification
The mode decode is driven with all eight values of the three mode bits. This separates the bypass-over-off priority from the storage-bit split between the screening modes. Frame strobes are sent on both buses at once with different hit values. This shows whether each mode uses the fixed outcome or the lookup hit, and per-bus disables show that the enable gating is done per bus. Boundary writes are tried in halted and running modes with values that overflow 10 bits. This separates the write protection from the field masking, and a hardware off pulse from each running mode checks the forced transition.

// File: rtl/acf_pkg.sv
package acf_pkg;
   typedef enum logic [1:0] {
      AM_DISCARD = 2'd0,
      AM_PASS    = 2'd1,
      AM_SCREEN  = 2'd2,
      AM_HWSTORE = 2'd3
   } acf_mode_e;

   localparam int MODE_BITS = 3;
   localparam int B_OFF     = 0;
   localparam int B_BYP     = 1;
   localparam int B_STORE   = 2;
endpackage

// File: rtl/acf_regs.sv
module acf_regs #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_SECT = 5,
   parameter int SECT_W   = 10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              psel,
   input  logic                              penable,
   input  logic                              pwrite,
   input  logic [ADDR_W-1:0]                 paddr,
   input  logic [DATA_W-1:0]                 pwdata,
   output logic [DATA_W-1:0]                 prdata,
   input  logic                              hw_off_req,
   input  logic                              wr_open,
   output logic [acf_pkg::MODE_BITS-1:0]     mode_bits,
   output logic [NUM_SECT-1:0][SECT_W-1:0]   sect_q
);
   import acf_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic             wr_stb;

   assign widx   = paddr[ADDR_W-1:2];
   assign wr_stb = psel & penable & pwrite;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_bits <= MODE_BITS'(1 << B_OFF);
      end else begin
         if (wr_stb && widx == '0)
            mode_bits <= pwdata[MODE_BITS-1:0];
         if (hw_off_req)
            mode_bits[B_OFF] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sect_q <= '0;
      end else begin
         for (int k = 0; k < NUM_SECT; k++) begin
            if (wr_stb && wr_open && widx == IDX_W'(k + 1))
               sect_q[k] <= pwdata[SECT_W-1:0];
         end
      end
   end

   always_comb begin
      prdata = '0;
      if (widx == '0)
         prdata[MODE_BITS-1:0] = mode_bits;
      for (int k = 0; k < NUM_SECT; k++) begin
         if (widx == IDX_W'(k + 1))
            prdata[SECT_W-1:0] = sect_q[k];
      end
   end
endmodule

// File: rtl/acf_mode_dec.sv
module acf_mode_dec (
   input  logic [acf_pkg::MODE_BITS-1:0] mode_bits,
   output acf_pkg::acf_mode_e            mode,
   output logic                          halt
);
   import acf_pkg::*;

   always_comb begin
      if (mode_bits[B_BYP])
         mode = AM_PASS;
      else if (mode_bits[B_OFF])
         mode = AM_DISCARD;
      else if (mode_bits[B_STORE])
         mode = AM_HWSTORE;
      else
         mode = AM_SCREEN;
   end

   assign halt = mode_bits[B_BYP] | mode_bits[B_OFF];
endmodule

// File: rtl/acf_rx_gate.sv
module acf_rx_gate (
   input  logic               clk,
   input  logic               rst_n,
   input  acf_pkg::acf_mode_e mode,
   input  logic               strobe,
   input  logic               enable,
   input  logic               hit,
   output logic               valid_q,
   output logic               accept_q
);
   import acf_pkg::*;

   logic verdict;

   always_comb begin
      case (mode)
         AM_PASS:    verdict = 1'b1;
         AM_DISCARD: verdict = 1'b0;
         default:    verdict = hit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         accept_q <= 1'b0;
      end else begin
         valid_q  <= strobe;
         accept_q <= strobe & enable & verdict;
      end
   end
endmodule

// File: rtl/acf_ctl.sv
module acf_ctl #(
   parameter int ADDR_W   = 12,
   parameter int NUM_SECT = 5,
   parameter int SECT_W   = 10,
   parameter int NUM_BUS  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        psel,
   input  logic                        penable,
   input  logic                        pwrite,
   input  logic [ADDR_W-1:0]           paddr,
   input  logic [31:0]                 pwdata,
   output logic [31:0]                 prdata,
   output logic                        pready,
   output logic                        pslverr,
   input  logic                        hw_off_req,
   input  logic [NUM_BUS-1:0]          rx_strobe,
   input  logic [NUM_BUS-1:0]          bus_en,
   input  logic [NUM_BUS-1:0]          screen_hit,
   output logic [1:0]                  filt_mode,
   output logic                        filt_halt,
   output logic [NUM_SECT*SECT_W-1:0]  sect_bound,
   output logic [NUM_BUS-1:0]          dec_valid,
   output logic [NUM_BUS-1:0]          dec_accept
);
   import acf_pkg::*;

   localparam int DATA_W = 32;
   localparam int MAP_W  = $clog2(NUM_SECT + 1);

   if (SECT_W < 1 || SECT_W > DATA_W) begin : g_bad_sect_w
      $error("SECT_W must lie in 1..32");
   end
   if (NUM_SECT < 1 || NUM_BUS < 1) begin : g_bad_count
      $error("NUM_SECT and NUM_BUS must be at least 1");
   end
   if (ADDR_W - 2 < MAP_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end

   logic [MODE_BITS-1:0]           mode_bits;
   logic [NUM_SECT-1:0][SECT_W-1:0] sect_q;
   acf_mode_e                      mode;
   logic                           halt;

   acf_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NUM_SECT(NUM_SECT),
      .SECT_W  (SECT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .prdata    (prdata),
      .hw_off_req(hw_off_req),
      .wr_open   (halt),
      .mode_bits (mode_bits),
      .sect_q    (sect_q)
   );

   acf_mode_dec u_dec (
      .mode_bits(mode_bits),
      .mode     (mode),
      .halt     (halt)
   );

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      acf_rx_gate u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode),
         .strobe  (rx_strobe[b]),
         .enable  (bus_en[b]),
         .hit     (screen_hit[b]),
         .valid_q (dec_valid[b]),
         .accept_q(dec_accept[b])
      );
   end

   assign pready     = 1'b1;
   assign pslverr    = 1'b0;
   assign filt_mode  = mode;
   assign filt_halt  = halt;
   assign sect_bound = sect_q;
endmodule

// File: rtl/acf_ctl_chk.sv
module acf_ctl_chk #(
   parameter int ADDR_W   = 12,
   parameter int NUM_SECT = 5,
   parameter int SECT_W   = 10,
   parameter int NUM_BUS  = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       psel,
   input logic                       penable,
   input logic                       pwrite,
   input logic [ADDR_W-1:0]          paddr,
   input logic                       hw_off_req,
   input logic [NUM_BUS-1:0]         rx_strobe,
   input logic [NUM_BUS-1:0]         bus_en,
   input logic [1:0]                 filt_mode,
   input logic                       filt_halt,
   input logic [NUM_SECT*SECT_W-1:0] sect_bound,
   input logic [NUM_BUS-1:0]         dec_valid,
   input logic [NUM_BUS-1:0]         dec_accept
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6: boundary writes while running do not change the boundaries
   a_r6_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && paddr[ADDR_W-1:2] != '0 && !filt_halt)
      |=> $stable(sect_bound));

   // R7: hardware off request ends any screening mode
   a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
      hw_off_req |=> (filt_mode == 2'd0 || filt_mode == 2'd1));

   // R8: decision valid follows the strobe by one cycle
   a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (dec_valid == $past(rx_strobe)));

   // R3: an enabled frame in pass-all mode is accepted
   a_r3_pass_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe[0] && bus_en[0] && filt_mode == 2'd1) |=> dec_accept[0]);

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus_chk
      // R9: a disabled bus never yields an accept
      a_r9_disabled_reject: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_en[b] |=> !dec_accept[b]);
   end
endmodule

bind acf_ctl acf_ctl_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_SECT(NUM_SECT),
   .SECT_W  (SECT_W),
   .NUM_BUS (NUM_BUS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .psel      (psel),
   .penable   (penable),
   .pwrite    (pwrite),
   .paddr     (paddr),
   .hw_off_req(hw_off_req),
   .rx_strobe (rx_strobe),
   .bus_en    (bus_en),
   .filt_mode (filt_mode),
   .filt_halt (filt_halt),
   .sect_bound(sect_bound),
   .dec_valid (dec_valid),
   .dec_accept(dec_accept)
);

// File: tb/sim_acf_ctl.sv
`timescale 1ns/1ps
module sim_acf_ctl;
   localparam int ADDR_W = 12;
   localparam int NS     = 5;
   localparam int SW     = 10;
   localparam int NB     = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [31:0]       pwdata = '0;
   logic [31:0]       prdata;
   logic              pready, pslverr;
   logic              hw_off_req = 1'b0;
   logic [NB-1:0]     rx_strobe = '0, bus_en = '0, screen_hit = '0;
   logic [1:0]        filt_mode;
   logic              filt_halt;
   logic [NS*SW-1:0]  sect_bound;
   logic [NB-1:0]     dec_valid, dec_accept;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   acf_ctl #(.ADDR_W(ADDR_W), .NUM_SECT(NS), .SECT_W(SW), .NUM_BUS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .hw_off_req(hw_off_req), .rx_strobe(rx_strobe),
      .bus_en(bus_en), .screen_hit(screen_hit), .filt_mode(filt_mode),
      .filt_halt(filt_halt), .sect_bound(sect_bound), .dec_valid(dec_valid),
      .dec_accept(dec_accept));

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         output logic err);
      @(negedge clk);
      psel = 1; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      #1 err = pslverr | ~pready;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      #1 d = prdata;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   task automatic set_mode(input logic [31:0] v);
      logic e;
      apb_wr('0, v, e);
   endtask

   task automatic frame(input logic [NB-1:0] en, input logic [NB-1:0] hit,
                        input logic [NB-1:0] exp_acc, input string req);
      @(negedge clk);
      rx_strobe = '1; bus_en = en; screen_hit = hit;
      @(negedge clk);
      rx_strobe = '0; bus_en = '0; screen_hit = '0;
      check(dec_valid == '1, "R8 valid", dec_valid, 2'b11);
      check(dec_accept == exp_acc, req, dec_accept, exp_acc);
      @(negedge clk);
      check(dec_valid == '0, "R8 valid drop", dec_valid, 2'b00);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check(filt_mode == 2'd0, "R1 mode", filt_mode, 0);
      check(filt_halt == 1'b1, "R1 halt", filt_halt, 1);
      apb_rd(12'h000, d);
      check(d == 32'h1, "R1 mode reg", d, 1);
      for (int k = 0; k < NS; k++) begin
         apb_rd(ADDR_W'(4 * (k + 1)), d);
         check(d == 0, "R1 section reset", d, 0);
      end
   endtask

   task automatic t_decode;
      logic [1:0] exp_m [8] = '{2'd2, 2'd0, 2'd1, 2'd1, 2'd3, 2'd0, 2'd1, 2'd1};
      for (int v = 0; v < 8; v++) begin
         set_mode(32'(v));
         check(filt_mode == exp_m[v], "R3 decode", filt_mode, exp_m[v]);
         check(filt_halt == (exp_m[v] < 2), "R4 halt", filt_halt, exp_m[v] < 2);
      end
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      set_mode(32'hFFFF_FFF8);
      apb_rd(12'h000, d);
      check(d == 32'h0, "R2 reserved", d, 0);
      set_mode(32'hFFFF_FFFD);
      apb_rd(12'h000, d);
      check(d == 32'h5, "R2 mode bits", d, 5);
      apb_rd(12'h040, d);
      check(d == 32'h0, "R10 unmapped read", d, 0);
   endtask

   task automatic t_sect_open;
      logic [31:0] d;
      logic e;
      set_mode(32'h1);
      for (int k = 0; k < NS; k++)
         apb_wr(ADDR_W'(4 * (k + 1)), 32'hFFFF_FC00 | 32'(16 * k + 3), e);
      for (int k = 0; k < NS; k++) begin
         apb_rd(ADDR_W'(4 * (k + 1)), d);
         check(d == 32'(16 * k + 3), "R5 section write off", d, 16 * k + 3);
      end
      set_mode(32'h2);
      apb_wr(12'h008, 32'h0000_03FF, e);
      apb_rd(12'h008, d);
      check(d == 32'h3FF, "R5 section write bypass", d, 32'h3FF);
      check(sect_bound[2*SW-1:SW] == 10'h3FF, "R5 bound output",
            sect_bound[2*SW-1:SW], 10'h3FF);
   endtask

   task automatic t_sect_locked;
      logic [31:0] d;
      logic e;
      set_mode(32'h0);
      apb_wr(12'h004, 32'h155, e);
      check(e == 1'b0, "R6 no error", e, 0);
      apb_rd(12'h004, d);
      check(d == 32'h3, "R6 locked screen", d, 3);
      set_mode(32'h4);
      apb_wr(12'h014, 32'h2AA, e);
      check(e == 1'b0, "R10 no error", e, 0);
      apb_rd(12'h014, d);
      check(d == 32'h43, "R6 locked store", d, 32'h43);
   endtask

   task automatic t_hw_off;
      logic [31:0] d;
      set_mode(32'h0);
      @(negedge clk); hw_off_req = 1;
      @(negedge clk); hw_off_req = 0;
      check(filt_mode == 2'd0, "R7 from screen", filt_mode, 0);
      apb_rd(12'h000, d);
      check(d == 32'h1, "R7 reg", d, 1);
      set_mode(32'h4);
      @(negedge clk); hw_off_req = 1;
      @(negedge clk); hw_off_req = 0;
      apb_rd(12'h000, d);
      check(d == 32'h5 && filt_mode == 2'd0, "R7 from store", d, 5);
   endtask

   task automatic t_frames;
      set_mode(32'h1); frame(2'b11, 2'b01, 2'b00, "R8 drop-all");
      set_mode(32'h3); frame(2'b11, 2'b01, 2'b11, "R8 pass-all");
      set_mode(32'h0); frame(2'b11, 2'b01, 2'b01, "R8 screen");
      set_mode(32'h4); frame(2'b11, 2'b10, 2'b10, "R8 screen store");
   endtask

   task automatic t_disable;
      set_mode(32'h2); frame(2'b10, 2'b00, 2'b10, "R9 pass disabled bus0");
      set_mode(32'h0); frame(2'b01, 2'b11, 2'b01, "R9 screen disabled bus1");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_decode;
      t_reserved;
      t_sect_open;
      t_sect_locked;
      t_hw_off;
      t_frames;
      t_disable;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule